// File: doc/BRIEF.md
# 8-bit Condition-Code ALU

This block is the purely combinational arithmetic and logic unit of a small 8-bit accumulator processor. Each cycle the surrounding datapath presents an operation code, two operand bytes and the current condition-code byte. Within the same cycle the block returns the result byte, the updated condition-code byte and a flag that says whether the result should be written back. Operand fetch and register writeback belong to the surrounding datapath.

Operations are split across four units that work side by side: a nine-bit adder/subtractor (add, add with carry, subtract, subtract with borrow, compare, negate, shift left), a logic unit (AND, OR, exclusive OR, bit test, test, complement, clear), a shift/count unit (logical and arithmetic shift right, rotate through carry in both directions, increment, decrement) and a decimal-adjust unit. A selector at the top picks one unit's outputs from the operation code. Unassigned operation codes behave as a no-operation.

Condition-code byte, bit 7 down to bit 0: E, F, H, I, N, Z, V, C.

Top module: `alu8_cc`

## Requirements
- R1: For every operation code, bits E (7), F (6) and I (4) of `cc_out` equal the same bits of `cc_in`.
- R2: ADD (0), ADC (1), SUB (2), SBC (3), CMP (4), NEG (9) and ASL (15) form a nine-bit sum s from left operand l and right operand r: ADD a+b, ADC a+b+C, SUB/CMP a-b, SBC a-b-C, NEG 0-a, ASL a+a. The result is s[7:0], H = bit 4 of l^r^s, V = bit 7 of l^r^s^(s>>1), C = s[8].
- R3: For all operations except DAA (20) and unassigned codes, N equals result bit 7 and Z is set exactly when the result byte is zero.
- R4: AND (5), OR (6), EOR (7), BIT (8, result a&b) and TST (18, result a) clear V and keep C and H.
- R5: COM (10) returns ~a, sets C and clears V. CLR (19) returns 0 with N=0, Z=1, V=0, C=0, and keeps H.
- R6: INC (16) returns a+1 and sets V only for a result of 0x80. DEC (17) returns a-1 and sets V only for a result of 0x7F. Neither changes C or H.
- R7: DAA (20) works on a: it adds 6 if H is set or the low nibble exceeds 9, then adds 0x60 if C is set or the high nibble of that sum exceeds 9. It sets C when the sum passes bit 7 and never clears C. N, Z, V and H are kept.
- R8: ROR (13) returns {C, a[7:1]} and ROL (14) returns {a[6:0], C}. The bit shifted out goes to C. ROL sets V = a[7]^a[6]. ROR keeps V, and both keep H.
- R9: LSR (11) returns {0, a[7:1]} and ASR (12) returns {a[7], a[7:1]}. Both put a[0] into C and keep V and H.
- R10: SBC and ADC use the incoming C as borrow or carry. After SUB, SBC, CMP or NEG, C=1 means an unsigned borrow occurred.
- R11: `res_wr` is 0 for CMP, BIT, TST and unassigned codes (21 to 31), and 1 for every other code.
- R12: An unassigned code (21 to 31) returns `res_out` = `a_in` and `cc_out` = `cc_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 5 | Operation code |
| a_in | input | W (8) | Accumulator operand |
| b_in | input | W (8) | Second operand |
| cc_in | input | 8 | Incoming condition-code byte |
| res_out | output | W (8) | Result byte |
| cc_out | output | 8 | Updated condition-code byte |
| res_wr | output | 1 | Result should be written back |

## Verification
The bench builds the block with its default width of eight bits. That is the only width at which the decimal adjust and the bit-4 half-carry have a defined meaning, and the full 256-value operand space of each operation is then small enough to sweep at random. At that width every code from 0 to 31 is driven with random operands and random condition codes. A set of directed vectors also covers the signed overflow edges (0x7F+1, INC to 0x80, DEC to 0x7F, NEG of 0x80 and of zero), borrow through SBC, both DAA correction stages, a sticky DAA carry, and a code with no assigned operation.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3,
        OP_CMP = 5'd4,  OP_AND = 5'd5,  OP_OR  = 5'd6,  OP_EOR = 5'd7,
        OP_BIT = 5'd8,  OP_NEG = 5'd9,  OP_COM = 5'd10, OP_LSR = 5'd11,
        OP_ASR = 5'd12, OP_ROR = 5'd13, OP_ROL = 5'd14, OP_ASL = 5'd15,
        OP_INC = 5'd16, OP_DEC = 5'd17, OP_TST = 5'd18, OP_CLR = 5'd19,
        OP_DAA = 5'd20
    } alu_op_e;

    typedef enum logic [2:0] {
        UNIT_ARITH, UNIT_LOGIC, UNIT_SHIFT, UNIT_DECADJ, UNIT_NONE
    } unit_e;

    // condition-code bit positions
    localparam int CC_C = 0;
    localparam int CC_V = 1;
    localparam int CC_Z = 2;
    localparam int CC_N = 3;
    localparam int CC_I = 4;
    localparam int CC_H = 5;
    localparam int CC_F = 6;
    localparam int CC_E = 7;

    function automatic unit_e unit_of(alu_op_e op);
        unit_e u;
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC,
            OP_CMP, OP_NEG, OP_ASL:           u = UNIT_ARITH;
            OP_AND, OP_OR, OP_EOR, OP_BIT,
            OP_TST, OP_COM, OP_CLR:           u = UNIT_LOGIC;
            OP_LSR, OP_ASR, OP_ROR, OP_ROL,
            OP_INC, OP_DEC:                   u = UNIT_SHIFT;
            OP_DAA:                           u = UNIT_DECADJ;
            default:                          u = UNIT_NONE;
        endcase
        return u;
    endfunction

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [7:0]   cc_i,
    output logic [W-1:0] res,
    output logic [7:0]   cc_o
);
    localparam int HB = W / 2;

    logic [W:0]   lhs;
    logic [W:0]   rhs;
    logic [W:0]   sum;
    logic [W:0]   cin;
    logic [W-1:0] mix;

    always_comb begin
        cin = {{W{1'b0}}, cc_i[CC_C]};
        lhs = {1'b0, a};
        rhs = {1'b0, b};
        sum = lhs + rhs;
        unique case (op)
            OP_ADD:         sum = lhs + rhs;
            OP_ADC:         sum = lhs + rhs + cin;
            OP_SUB, OP_CMP: sum = lhs - rhs;
            OP_SBC:         sum = lhs - rhs - cin;
            OP_NEG: begin
                lhs = '0;
                rhs = {1'b0, a};
                sum = lhs - rhs;
            end
            OP_ASL: begin
                rhs = {1'b0, a};
                sum = lhs + rhs;
            end
            default: ;
        endcase
        mix  = lhs[W-1:0] ^ rhs[W-1:0] ^ sum[W-1:0];
        res  = sum[W-1:0];
        cc_o = cc_i;
        cc_o[CC_H] = mix[HB];
        cc_o[CC_V] = mix[W-1] ^ sum[W];
        cc_o[CC_C] = sum[W];
        cc_o[CC_N] = sum[W-1];
        cc_o[CC_Z] = ~|sum[W-1:0];
    end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [7:0]   cc_i,
    output logic [W-1:0] res,
    output logic [7:0]   cc_o
);
    always_comb begin
        res  = a;
        cc_o = cc_i;
        unique case (op)
            OP_AND, OP_BIT: res = a & b;
            OP_OR:          res = a | b;
            OP_EOR:         res = a ^ b;
            OP_COM: begin
                res = ~a;
                cc_o[CC_C] = 1'b1;
            end
            OP_CLR: begin
                res = '0;
                cc_o[CC_C] = 1'b0;
            end
            default: res = a;
        endcase
        cc_o[CC_V] = 1'b0;
        cc_o[CC_N] = res[W-1];
        cc_o[CC_Z] = ~|res;
    end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [7:0]   cc_i,
    output logic [W-1:0] res,
    output logic [7:0]   cc_o
);
    localparam logic [W-1:0] SIGN_MIN = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] SIGN_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

    always_comb begin
        res  = a;
        cc_o = cc_i;
        unique case (op)
            OP_LSR: begin
                res = {1'b0, a[W-1:1]};
                cc_o[CC_C] = a[0];
            end
            OP_ASR: begin
                res = {a[W-1], a[W-1:1]};
                cc_o[CC_C] = a[0];
            end
            OP_ROR: begin
                res = {cc_i[CC_C], a[W-1:1]};
                cc_o[CC_C] = a[0];
            end
            OP_ROL: begin
                res = {a[W-2:0], cc_i[CC_C]};
                cc_o[CC_C] = a[W-1];
                cc_o[CC_V] = a[W-1] ^ a[W-2];
            end
            OP_INC: begin
                res = a + ONE;
                cc_o[CC_V] = (res == SIGN_MIN);
            end
            OP_DEC: begin
                res = a - ONE;
                cc_o[CC_V] = (res == SIGN_MAX);
            end
            default: res = a;
        endcase
        cc_o[CC_N] = res[W-1];
        cc_o[CC_Z] = ~|res;
    end
endmodule

// File: rtl/alu8_decadj.sv
module alu8_decadj
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [7:0]   cc_i,
    output logic [W-1:0] res,
    output logic [7:0]   cc_o
);
    localparam int        HB      = W / 2;
    localparam logic [W:0] LO_FIX = (W+1)'(6);
    localparam logic [W:0] HI_FIX = (W+1)'(6) << HB;

    logic [W:0] t;

    always_comb begin
        t = {1'b0, a};
        if (cc_i[CC_H] || (t[HB-1:0] > HB'(9)))
            t = t + LO_FIX;
        if (cc_i[CC_C] || (t[W-1:HB] > (W-HB)'(9)))
            t = t + HI_FIX;
        res  = t[W-1:0];
        cc_o = cc_i;
        if (t[W])
            cc_o[CC_C] = 1'b1;
    end
endmodule

// File: rtl/alu8_cc.sv
module alu8_cc
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [OP_W-1:0] op_sel,
    input  logic [W-1:0]    a_in,
    input  logic [W-1:0]    b_in,
    input  logic [7:0]      cc_in,
    output logic [W-1:0]    res_out,
    output logic [7:0]      cc_out,
    output logic            res_wr
);
    alu_op_e      op_e;
    unit_e        unit;
    logic [W-1:0] ar_res, lg_res, sh_res, da_res;
    logic [7:0]   ar_cc,  lg_cc,  sh_cc,  da_cc;

    assign op_e = alu_op_e'(op_sel);
    assign unit = unit_of(op_e);

    alu8_arith #(.W(W)) u_arith (
        .op(op_e), .a(a_in), .b(b_in), .cc_i(cc_in), .res(ar_res), .cc_o(ar_cc)
    );
    alu8_logic #(.W(W)) u_logic (
        .op(op_e), .a(a_in), .b(b_in), .cc_i(cc_in), .res(lg_res), .cc_o(lg_cc)
    );
    alu8_shift #(.W(W)) u_shift (
        .op(op_e), .a(a_in), .cc_i(cc_in), .res(sh_res), .cc_o(sh_cc)
    );
    alu8_decadj #(.W(W)) u_decadj (
        .a(a_in), .cc_i(cc_in), .res(da_res), .cc_o(da_cc)
    );

    always_comb begin
        res_wr = 1'b1;
        unique case (unit)
            UNIT_ARITH:  begin res_out = ar_res; cc_out = ar_cc; end
            UNIT_LOGIC:  begin res_out = lg_res; cc_out = lg_cc; end
            UNIT_SHIFT:  begin res_out = sh_res; cc_out = sh_cc; end
            UNIT_DECADJ: begin res_out = da_res; cc_out = da_cc; end
            default: begin
                res_out = a_in;
                cc_out  = cc_in;
                res_wr  = 1'b0;
            end
        endcase
        if (op_e == OP_CMP || op_e == OP_BIT || op_e == OP_TST)
            res_wr = 1'b0;
    end

    always_comb begin
        AST_MODE_BITS_KEPT: assert ({cc_out[CC_E], cc_out[CC_F], cc_out[CC_I]} ==
                                    {cc_in[CC_E], cc_in[CC_F], cc_in[CC_I]}); // R1
        if (unit == UNIT_ARITH || unit == UNIT_LOGIC || unit == UNIT_SHIFT)
            AST_ZERO_MATCHES: assert (cc_out[CC_Z] == (res_out == '0)); // R3
        if (op_e == OP_INC || op_e == OP_DEC)
            AST_COUNT_KEEPS_C: assert (cc_out[CC_C] == cc_in[CC_C]); // R6
        if (op_e == OP_COM)
            AST_COM_FLAGS: assert (cc_out[CC_C] && !cc_out[CC_V]); // R5
        if (op_e == OP_DAA && cc_in[CC_C])
            AST_DAA_STICKY_C: assert (cc_out[CC_C]); // R7
        if (unit == UNIT_LOGIC)
            AST_LOGIC_KEEPS_H: assert (cc_out[CC_H] == cc_in[CC_H]); // R4
    end
endmodule

// File: tb/alu8_cc_test.sv
`timescale 1ns/1ps
module alu8_cc_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] op_sel = '0;
    logic [7:0] a_in = '0, b_in = '0, cc_in = '0;
    logic [7:0] res_out, cc_out;
    logic       res_wr;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    alu8_cc uut (
        .op_sel(op_sel), .a_in(a_in), .b_in(b_in), .cc_in(cc_in),
        .res_out(res_out), .cc_out(cc_out), .res_wr(res_wr)
    );

    function automatic string tag_of(int op);
        case (op)
            0, 15:        return "R2";
            1, 3:         return "R10";
            2, 4, 9:      return "R2/R10";
            5, 6, 7, 8, 18: return "R4";
            10, 19:       return "R5";
            16, 17:       return "R6";
            20:           return "R7";
            13, 14:       return "R8";
            11, 12:       return "R9";
            default:      return "R12";
        endcase
    endfunction

    // behavioural reference
    task automatic model(input int op, input int a, input int b, input int cc,
                         output int r, output int f, output int wr);
        int h, v, c, n, z, l, rr, s, t;
        bit nz;
        h = (cc >> 5) & 1; v = (cc >> 1) & 1; c = cc & 1;
        n = (cc >> 3) & 1; z = (cc >> 2) & 1;
        r = a; wr = 1; nz = 1; l = 0; rr = 0; s = -1;
        case (op)
            0:  begin l = a; rr = b; s = a + b; end
            1:  begin l = a; rr = b; s = a + b + c; end
            2, 4: begin l = a; rr = b; s = a - b; end
            3:  begin l = a; rr = b; s = a - b - c; end
            9:  begin l = 0; rr = a; s = -a; end
            15: begin l = a; rr = a; s = 2 * a; end
            5, 8: begin r = a & b; v = 0; end
            6:  begin r = a | b; v = 0; end
            7:  begin r = a ^ b; v = 0; end
            18: begin r = a; v = 0; end
            10: begin r = 255 - a; v = 0; c = 1; end
            19: begin r = 0; v = 0; c = 0; end
            11: begin c = a & 1; r = a / 2; end
            12: begin c = a & 1; r = a / 2 + (a & 128); end
            13: begin r = a / 2 + 128 * c; c = a & 1; end
            14: begin r = (a * 2 + c) % 256; c = a / 128;
                      v = ((a >> 7) ^ (a >> 6)) & 1; end
            16: begin r = (a + 1) % 256; v = (r == 128); end
            17: begin r = (a + 255) % 256; v = (r == 127); end
            20: begin
                t = a;
                if (h == 1 || (t % 16) > 9) t = t + 6;
                if (c == 1 || (t & 'hF0) > 'h90) t = t + 'h60;
                if (t >= 256) c = 1;
                r = t % 256; nz = 0;
            end
            default: begin r = a; wr = 0; nz = 0; end
        endcase
        if (s != -1 || op == 9 || op == 2 || op == 3 || op == 4) begin
            s = s & 'h1FF;
            h = ((l ^ rr ^ s) >> 4) & 1;
            v = ((l ^ rr ^ s ^ (s >> 1)) >> 7) & 1;
            c = (s >> 8) & 1;
            r = s & 255;
        end
        if (op == 4 || op == 8 || op == 18) wr = 0;
        if (nz) begin n = (r >> 7) & 1; z = (r == 0); end
        f = (cc & 'hD0) | (h << 5) | (n << 3) | (z << 2) | (v << 1) | c;
        if (op > 20) f = cc;
    endtask

    task automatic run(input int op, input int a, input int b, input int cc);
        int er, ef, ew;
        @(posedge clk);
        #1;
        op_sel = op[4:0]; a_in = a[7:0]; b_in = b[7:0]; cc_in = cc[7:0];
        model(op, a, b, cc, er, ef, ew);
        @(negedge clk);
        checks++;
        if (res_out !== er[7:0] || cc_out !== ef[7:0] || res_wr !== ew[0]) begin
            errors++;
            $display("FAIL %s op=%0d a=%h b=%h cc=%h : got res=%h cc=%h wr=%b expected res=%h cc=%h wr=%b (R1/R3/R11)",
                     tag_of(op), op, a[7:0], b[7:0], cc[7:0], res_out, cc_out, res_wr,
                     er[7:0], ef[7:0], ew[0]);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // idle state after reset: ADD of zeros, R3 sets Z
        run(0, 0, 0, 0);
        run(0, 'h7F, 'h01, 0);      // R2 overflow and half carry
        run(0, 'hFF, 'h01, 0);      // R2 carry out, zero
        run(1, 'h10, 'h20, 1);      // R10 carry in
        run(2, 'h00, 'h01, 0);      // R10 borrow
        run(3, 'h10, 'h10, 1);      // R10 borrow in
        run(4, 'h05, 'h05, 'hFF);   // R11 compare no write
        run(9, 'h80, 0, 0);         // R2 negate minimum
        run(9, 'h00, 0, 1);         // R2 negate zero
        run(15, 'hC0, 0, 0);        // R2 shift left
        run(8, 'hF0, 'h0F, 'h23);   // R4 bit test
        run(10, 'h00, 0, 'h02);     // R5
        run(19, 'h55, 0, 'h2B);     // R5 clear
        run(16, 'h7F, 0, 1);        // R6
        run(17, 'h80, 0, 0);        // R6
        run(20, 'h9A, 0, 0);        // R7 both corrections
        run(20, 'h15, 0, 'h20);     // R7 half carry
        run(20, 'h12, 0, 'h01);     // R7 carry stays set
        run(13, 'h01, 0, 1);        // R8
        run(14, 'h40, 0, 0);        // R8 V from bits 7 and 6
        run(11, 'h81, 0, 0);        // R9
        run(12, 'h81, 0, 0);        // R9
        run(25, 'h3C, 'h11, 'hA5);  // R12 unassigned code
        for (int op = 0; op < 32; op++) begin
            for (int k = 0; k < 300; k++)
                run(op, int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
                    int'($urandom_range(0, 255)));
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule